// File: doc/BRIEF.md
# Eight-Pin GPIO Bank with Change Interrupt

This block is the register bank and pin control of a small general purpose I/O port. A host reaches eight registers through a plain address/data interface with separate read and write strobes. The registers set the direction of each pin, the value driven on output pins, the polarity of the input readback, the bus-hold and pull-resistor controls, and a per-pin interrupt mask. The block turns these registers into per-pin output-enable, output-value and pull-control signals for the pad ring.

Pin levels pass through a two-flop synchronizer. Each read of the input register takes a snapshot of the synchronized levels. An unmasked input pin whose level differs from that snapshot pulls the active-low interrupt output low. The interrupt releases when the pin returns to its snapshot level, or when the host reads the input register again. A status register shows which pins are causing the interrupt.

Top module: `gpio_bank`

## Requirements
- R1: The register addresses are: 0 input (read-only), 1 polarity, 2 hold/pull enable, 3 pull select, 4 direction, 5 output, 6 mask, 7 status (read-only). Registers 1, 3, 4, 5 and 6 read back the last value written. Register 2 keeps only bits 1:0 and reads back bits 7:2 as zero.
- R2: After reset the registers read: polarity 00h, enable 00h, pull select FFh, direction FFh, output 00h, mask FFh, status 00h. The captured input image is 00h.
- R3: Direction bit 1 makes the pin an input, with `pin_oe_o` low. Direction bit 0 drives `pin_oe_o` high. `pin_out_o` always carries the output register.
- R4: Register 0 reads the synchronized pin levels XOR the polarity register, for inputs and outputs alike. A pin change appears there after the second rising clock edge, and not after the first.
- R5: `hold_en_o` equals enable bit 0. Each `pull_en_o` bit is 1 only when enable bit 1 is 1 and enable bit 0 is 0. `pull_up_o` carries the pull-select register, where 1 selects a pull-up and 0 a pull-down.
- R6: `int_no` is low exactly when some pin meets all three conditions: its direction bit is 1, its mask bit is 0, and its synchronized level differs from the image captured at the last read of register 0.
- R7: Bit n of register 7 is 1 exactly when pin n meets the R6 condition. Masked pins and output pins read 0.
- R8: A read of register 0 captures the current synchronized levels as the new image, which clears any pending change. A pin that returns to its image level also clears its own change.
- R9: Writes to registers 0 and 7 change no register and no output.
- R10: Register 5 reads back the stored output value, whatever the pin level.
- R11: Turning a pin from output to input raises the interrupt when the pin is unmasked and its level differs from the captured image.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Write strobe |
| rd_en_i | input | 1 | Read strobe; with address 0 it captures the input image |
| addr_i | input | 3 | Register address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Read data for addr_i (combinational) |
| pin_i | input | 8 | Asynchronous pin levels |
| pin_oe_o | output | 8 | Per-pin output enable |
| pin_out_o | output | 8 | Per-pin output value |
| hold_en_o | output | 1 | Bus-hold enable for the bank |
| pull_en_o | output | 8 | Per-pin pull-resistor enable |
| pull_up_o | output | 8 | Per-pin pull direction, 1 = up |
| int_no | output | 1 | Active-low interrupt, open-drain style |

## Verification
The assertions check, on every cycle, four things: that a direction write reaches the output enables one cycle later, that a mask write of FFh releases the interrupt, that bus-hold and pulls are never on together, and that a read of register 0 loads the image and status never shows a masked pin. Other behaviour depends on the order of stimulus and needs the bench's scenarios. This covers the two-edge synchronizer latency, an interrupt clearing when a pin returns or after a read, the false interrupt when a pin turns from output to input, and writes to the read-only addresses having no effect.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
  typedef enum logic [2:0] {
    REG_IN   = 3'd0,
    REG_POL  = 3'd1,
    REG_EN   = 3'd2,
    REG_PSEL = 3'd3,
    REG_DIR  = 3'd4,
    REG_OUT  = 3'd5,
    REG_MASK = 3'd6,
    REG_STAT = 3'd7
  } reg_addr_e;

  localparam int unsigned EN_W = 2;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] stg_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stg
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) stg_q[s] <= '0;
      else if (s == 0) stg_q[s] <= d_i;
      else stg_q[s] <= stg_q[(s == 0) ? 0 : s-1];
    end
  end

  assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic [2:0]      addr_i,
  input  logic [W-1:0]    wdata_i,
  output logic [W-1:0]    pol_o,
  output logic [EN_W-1:0] en_o,
  output logic [W-1:0]    psel_o,
  output logic [W-1:0]    dir_o,
  output logic [W-1:0]    out_o,
  output logic [W-1:0]    mask_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_o  <= '0;
      en_o   <= '0;
      psel_o <= '1;
      dir_o  <= '1;
      out_o  <= '0;
      mask_o <= '1;
    end else if (wr_en_i) begin
      unique case (reg_addr_e'(addr_i))
        REG_POL:  pol_o  <= wdata_i;
        REG_EN:   en_o   <= wdata_i[EN_W-1:0];
        REG_PSEL: psel_o <= wdata_i;
        REG_DIR:  dir_o  <= wdata_i;
        REG_OUT:  out_o  <= wdata_i;
        REG_MASK: mask_o <= wdata_i;
        default: ;  // input and status are read-only
      endcase
    end
  end
endmodule

// File: rtl/gpio_irq.sv
module gpio_irq #(
  parameter int unsigned W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         snap_en_i,
  input  logic [W-1:0] lvl_i,
  input  logic [W-1:0] dir_i,
  input  logic [W-1:0] mask_i,
  output logic [W-1:0] snap_o,
  output logic [W-1:0] stat_o,
  output logic         int_no
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_o <= '0;
    else if (snap_en_i) snap_o <= lvl_i;
  end

  // change vs. last-read image, inputs only, unmasked only
  assign stat_o = (lvl_i ^ snap_o) & dir_i & ~mask_i;
  assign int_no = ~|stat_o;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NPIN        = 8,
  parameter int unsigned SYNC_STAGES = 2,
  localparam int unsigned AW = 3
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            wr_en_i,
  input  logic            rd_en_i,
  input  logic [AW-1:0]   addr_i,
  input  logic [NPIN-1:0] wdata_i,
  output logic [NPIN-1:0] rdata_o,
  input  logic [NPIN-1:0] pin_i,
  output logic [NPIN-1:0] pin_oe_o,
  output logic [NPIN-1:0] pin_out_o,
  output logic            hold_en_o,
  output logic [NPIN-1:0] pull_en_o,
  output logic [NPIN-1:0] pull_up_o,
  output logic            int_no
);
  logic [NPIN-1:0] sync_q, pol_q, psel_q, dir_q, out_q, mask_q, snap_q, stat;
  logic [EN_W-1:0] en_q;
  logic            snap_en;

  gpio_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
    .clk_i, .rst_ni, .d_i(pin_i), .q_o(sync_q)
  );

  gpio_regs #(.W(NPIN)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .addr_i, .wdata_i,
    .pol_o(pol_q), .en_o(en_q), .psel_o(psel_q),
    .dir_o(dir_q), .out_o(out_q), .mask_o(mask_q)
  );

  assign snap_en = rd_en_i && (reg_addr_e'(addr_i) == REG_IN);

  gpio_irq #(.W(NPIN)) u_irq (
    .clk_i, .rst_ni, .snap_en_i(snap_en), .lvl_i(sync_q),
    .dir_i(dir_q), .mask_i(mask_q), .snap_o(snap_q),
    .stat_o(stat), .int_no
  );

  always_comb begin
    rdata_o = '0;
    unique case (reg_addr_e'(addr_i))
      REG_IN:   rdata_o = sync_q ^ pol_q;
      REG_POL:  rdata_o = pol_q;
      REG_EN:   rdata_o[EN_W-1:0] = en_q;
      REG_PSEL: rdata_o = psel_q;
      REG_DIR:  rdata_o = dir_q;
      REG_OUT:  rdata_o = out_q;
      REG_MASK: rdata_o = mask_q;
      REG_STAT: rdata_o = stat;
      default:  rdata_o = '0;
    endcase
  end

  assign pin_oe_o  = ~dir_q;
  assign pin_out_o = out_q;
  assign hold_en_o = en_q[0];
  assign pull_en_o = {NPIN{en_q[1] & ~en_q[0]}};
  assign pull_up_o = psel_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
  parameter int unsigned NPIN = 8
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            wr_en_i,
  input logic            rd_en_i,
  input logic [2:0]      addr_i,
  input logic [NPIN-1:0] wdata_i,
  input logic [NPIN-1:0] rdata_o,
  input logic [NPIN-1:0] pin_oe_o,
  input logic            hold_en_o,
  input logic [NPIN-1:0] pull_en_o,
  input logic            int_no,
  input logic [NPIN-1:0] mask_q,
  input logic [NPIN-1:0] sync_q,
  input logic [NPIN-1:0] snap_q
);
  a_r3_dir_to_oe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd4) |=> (pin_oe_o == ~$past(wdata_i)));

  a_r6_full_mask_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == 3'd6 && wdata_i == '1) |=> int_no);

  a_r5_hold_no_pull: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_en_o |-> (pull_en_o == '0));

  a_r8_read_captures: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && addr_i == 3'd0) |=> (snap_q == $past(sync_q)));

  a_r7_stat_masked_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (addr_i == 3'd7) |-> ((rdata_o & mask_q) == '0));
endmodule

bind gpio_bank gpio_bank_chk #(.NPIN(NPIN)) u_chk (
  .clk_i, .rst_ni, .wr_en_i, .rd_en_i, .addr_i, .wdata_i, .rdata_o,
  .pin_oe_o, .hold_en_o, .pull_en_o, .int_no,
  .mask_q(mask_q), .sync_q(sync_q), .snap_q(snap_q)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;
  logic       clk = 0, rst_n = 0;
  logic       wr_en = 0, rd_en = 0;
  logic [2:0] addr = 0;
  logic [7:0] wdata = 0, pins = 0;
  logic [7:0] rdata, oe, pout, pull_en, pull_up;
  logic       hold, int_n;

  int total = 0, bad = 0;
  logic [7:0] m_pol, m_psel, m_dir, m_out, m_mask, m_snap, m_pins;
  logic [1:0] m_en;

  always #2 clk = ~clk;

  gpio_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .rd_en_i(rd_en),
    .addr_i(addr), .wdata_i(wdata), .rdata_o(rdata), .pin_i(pins),
    .pin_oe_o(oe), .pin_out_o(pout), .hold_en_o(hold),
    .pull_en_o(pull_en), .pull_up_o(pull_up), .int_no(int_n)
  );

  function automatic logic [7:0] f_stat();
    return (m_pins ^ m_snap) & m_dir & ~m_mask;
  endfunction

  function automatic logic [7:0] f_rd(input logic [2:0] a);
    case (a)
      3'd0: return m_pins ^ m_pol;
      3'd1: return m_pol;
      3'd2: return {6'b0, m_en};
      3'd3: return m_psel;
      3'd4: return m_dir;
      3'd5: return m_out;
      3'd6: return m_mask;
      default: return f_stat();
    endcase
  endfunction

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%02h exp=%02h t=%0t", req, act, exp, $time);
    end
  endtask

  task automatic chk_outs(input string req);
    chk({req, " oe R3"}, oe, ~m_dir);
    chk({req, " out R3"}, pout, m_out);
    chk({req, " hold R5"}, {7'b0, hold}, {7'b0, m_en[0]});
    chk({req, " pull_en R5"}, pull_en, {8{m_en[1] & ~m_en[0]}});
    chk({req, " pull_up R5"}, pull_up, m_psel);
    chk({req, " int R6"}, {7'b0, int_n}, {7'b0, f_stat() == 8'h00});
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0;
    case (a)
      3'd1: m_pol = d;
      3'd2: m_en = d[1:0];
      3'd3: m_psel = d;
      3'd4: m_dir = d;
      3'd5: m_out = d;
      3'd6: m_mask = d;
      default: ;
    endcase
  endtask

  task automatic rd(input logic [2:0] a, input string req);
    @(negedge clk);
    rd_en = 1; addr = a;
    #1 chk(req, rdata, f_rd(a));
    @(negedge clk);
    rd_en = 0;
    if (a == 3'd0) m_snap = m_pins;
  endtask

  task automatic set_pins(input logic [7:0] v);
    @(negedge clk);
    pins = v;
    repeat (3) @(negedge clk);
    m_pins = v;
  endtask

  initial begin
    #(4 * 200000);
    bad++;
    $display("FAIL watchdog expired");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0a11));
    m_pol = 0; m_en = 0; m_psel = 8'hff; m_dir = 8'hff;
    m_out = 0; m_mask = 8'hff; m_snap = 0; m_pins = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R2: reset defaults
    for (int a = 1; a < 8; a++) rd(3'(a), "R2 reset reg");
    chk_outs("R2 reset");

    // R4: two-edge latency and polarity
    @(negedge clk); pins = 8'h5a; addr = 3'd0;
    @(negedge clk); #1 chk("R4 after one edge", rdata, 8'h00);
    @(negedge clk); #1 chk("R4 after two edges", rdata, 8'h5a);
    m_pins = 8'h5a;
    wr(3'd1, 8'h0f);
    rd(3'd0, "R4 polarity");

    // R1/R5: enable readback and hold/pull
    wr(3'd2, 8'hfe); rd(3'd2, "R1 enable upper zero"); chk_outs("R5 pull on");
    wr(3'd2, 8'h03); chk_outs("R5 hold beats pull");

    // R10: output readback independent of pins
    wr(3'd4, 8'h00); wr(3'd5, 8'ha5); rd(3'd5, "R10 out readback");
    wr(3'd4, 8'hff);

    // R6/R7/R8 directed on pin 0
    rd(3'd0, "R8 capture");
    wr(3'd6, 8'hfe);
    set_pins(m_pins ^ 8'h01);
    chk_outs("R6 change");
    rd(3'd7, "R7 status one");
    set_pins(m_pins ^ 8'h01);
    chk_outs("R8 return clears");
    set_pins(m_pins ^ 8'h01);
    rd(3'd0, "R8 read image");
    chk_outs("R8 read clears");
    set_pins(m_pins ^ 8'h02);
    rd(3'd7, "R7 masked pin zero");

    // R11: output to input false interrupt on pin 3
    wr(3'd4, 8'hf7); wr(3'd6, 8'hf7);
    set_pins(m_pins ^ 8'h08);
    chk_outs("R11 output no int");
    wr(3'd4, 8'hff);
    chk_outs("R11 switch to input");

    // R9: writes to read-only addresses
    wr(3'd7, 8'hff); wr(3'd0, 8'hff);
    rd(3'd7, "R9 status kept"); rd(3'd0, "R9 input kept");
    chk_outs("R9 outputs");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 3);
      if (op == 0) wr(3'($urandom_range(0, 7)), 8'($urandom));
      else if (op == 1) set_pins(8'($urandom));
      else rd(3'($urandom_range(0, 7)), "R1 random read");
      chk_outs("R6 random");
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule